// File: doc/BRIEF.md
# Burst Sample Capture with Serial Upload

This block records one burst of receive-path converter samples at full sample rate and then sends the burst to a host over a slow serial line. Capture runs on the fast converter clock. Transmission runs on a separate, unrelated oscillator clock. Each 14-bit sample is sign-extended to a 16-bit word and written into a dual-port store. Each stored word is later sent as two serial bytes.

A single pulse on the request input arms one capture of `DEPTH` consecutive samples. When the store is full, a toggle handshake tells the slow domain to start sending. The serializer streams every word in capture order, low byte first. Each byte uses 8N1 framing at `BAUD` bit/s, derived from `SLOW_HZ`. After the stop bit of the final byte, a second toggle handshake returns completion to the fast domain and raises the done flag.

Capture and upload never overlap. A new request is accepted only when the previous upload has fully finished. This means the host always receives one complete burst with no repeated or missing words.

Top module: `capture_uart_dump`

## Requirements
- R1: While either reset is asserted, and after both are released with no request, `uart_tx` is 1 and `busy` and `done` are 0.
- R2: A request accepted while idle stores exactly `DEPTH` samples. The first stored sample is the one present at the fast clock edge that follows the accepting edge, and each later sample comes from the next edge in turn. `busy` is 1 from the cycle after the accepting edge.
- R3: Each stored word is the 14-bit sample with bit 13 copied into bits 15 and 14.
- R4: Words are sent in capture order, each as its low byte (bits 7..0) followed by its high byte (bits 15..8).
- R5: Every byte is framed as one start bit of 0, then eight data bits least significant first, then one stop bit of 1. Each bit lasts `SLOW_HZ/BAUD` slow clock cycles. The line is held at 1 whenever no burst is being sent.
- R6: A request that arrives while `busy` is 1 is ignored: no new capture starts and the burst being sent is unchanged.
- R7: `done` rises only after the stop bit of the last byte has completed. It stays 1 until the next request is accepted, and it is never 1 while `busy` is 1.
- R8: Each accepted request produces exactly `2*DEPTH` serial bytes and no more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fast_clk | input | 1 | Converter sample clock |
| fast_rst_n | input | 1 | Active-low asynchronous reset, fast domain |
| adc_sample | input | SAMPLE_W | Two's-complement converter sample |
| capture_req | input | 1 | Request to capture one burst (fast domain) |
| slow_clk | input | 1 | Serial side clock, independent oscillator |
| slow_rst_n | input | 1 | Active-low asynchronous reset, slow domain |
| uart_tx | output | 1 | Serial transmit line, idle high |
| busy | output | 1 | Capture or upload in progress (fast domain) |
| done | output | 1 | Last burst fully sent (fast domain) |

## Verification
Several properties are checked by assertions on every clock cycle:
- `busy` and `done` are never high together.
- `busy` rises only after a request, and `done` rises only out of a busy period.
- A capture always lasts exactly `DEPTH` cycles.
- A request that arrives during the wait for upload never restarts capture.
- The line idles high, a frame starts with a low bit, and the line is high just before the upload ends.

Other behaviours can only be shown by the bench's scenarios, which decode the serial line and compare the result with arithmetic expectations. These are: sample alignment, sign extension, byte order, bit timing, the exact byte count, and the burst staying unchanged after a request arrives during upload.

// File: rtl/capture_uart_dump.sv
module capture_uart_dump #(
  parameter int SAMPLE_W = 14,
  parameter int WORD_W   = 16,
  parameter int DEPTH    = 16,
  parameter int SLOW_HZ  = 1843200,
  parameter int BAUD     = 115200
) (
  input  logic                fast_clk,
  input  logic                fast_rst_n,
  input  logic [SAMPLE_W-1:0] adc_sample,
  input  logic                capture_req,
  input  logic                slow_clk,
  input  logic                slow_rst_n,
  output logic                uart_tx,
  output logic                busy,
  output logic                done
);
  localparam int DIV   = SLOW_HZ / BAUD;
  localparam int DCW   = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int NB    = 2 * DEPTH;
  localparam int BW    = $clog2(NB) + 1;
  localparam int EXT_W = WORD_W - SAMPLE_W;

  typedef enum logic [1:0] {F_IDLE, F_CAP, F_WAIT} fstate_t;

  logic [WORD_W-1:0] store [DEPTH];
  fstate_t           f_state;
  logic [AW-1:0]     wr_addr;
  logic              cap_tgl, done_r;
  logic [2:0]        up_sync;
  logic              up_tgl;
  logic              capturing, waiting;

  logic [WORD_W-1:0] ext_sample;
  assign ext_sample = {{EXT_W{adc_sample[SAMPLE_W-1]}}, adc_sample};
  assign capturing  = (f_state == F_CAP);
  assign waiting    = (f_state == F_WAIT);
  assign busy       = (f_state != F_IDLE);
  assign done       = done_r;

  always_ff @(posedge fast_clk)
    if (capturing) store[wr_addr] <= ext_sample;

  always_ff @(posedge fast_clk or negedge fast_rst_n) begin
    if (!fast_rst_n) begin
      f_state <= F_IDLE;
      wr_addr <= '0;
      cap_tgl <= 1'b0;
      done_r  <= 1'b0;
      up_sync <= '0;
    end else begin
      up_sync <= {up_sync[1:0], up_tgl};
      case (f_state)
        F_IDLE:
          if (capture_req) begin
            f_state <= F_CAP;
            wr_addr <= '0;
            done_r  <= 1'b0;
          end
        F_CAP: begin
          wr_addr <= wr_addr + 1'b1;
          if (wr_addr == AW'(DEPTH - 1)) begin
            f_state <= F_WAIT;
            cap_tgl <= ~cap_tgl;
          end
        end
        F_WAIT:
          if (up_sync[2] ^ up_sync[1]) begin
            f_state <= F_IDLE;
            done_r  <= 1'b1;
          end
        default: f_state <= F_IDLE;
      endcase
    end
  end

  logic [2:0]        cap_sync;
  logic              up_active;
  logic [BW-1:0]     byte_idx, nb_idx;
  logic [3:0]        bit_idx;
  logic [DCW-1:0]    baud_cnt;
  logic [8:0]        shreg;
  logic              tx_r;
  logic [WORD_W-1:0] nb_word;
  logic [7:0]        nb_byte;
  logic              start_up;

  assign start_up = cap_sync[2] ^ cap_sync[1];
  assign nb_idx   = up_active ? byte_idx + 1'b1 : '0;
  assign nb_word  = store[nb_idx[BW-1:1]];
  assign nb_byte  = nb_idx[0] ? nb_word[15:8] : nb_word[7:0];
  assign uart_tx  = tx_r;

  always_ff @(posedge slow_clk or negedge slow_rst_n) begin
    if (!slow_rst_n) begin
      cap_sync  <= '0;
      up_active <= 1'b0;
      byte_idx  <= '0;
      bit_idx   <= '0;
      baud_cnt  <= '0;
      shreg     <= '1;
      tx_r      <= 1'b1;
      up_tgl    <= 1'b0;
    end else begin
      cap_sync <= {cap_sync[1:0], cap_tgl};
      if (!up_active) begin
        if (start_up) begin
          up_active <= 1'b1;
          byte_idx  <= '0;
          bit_idx   <= '0;
          baud_cnt  <= '0;
          shreg     <= {1'b1, nb_byte};
          tx_r      <= 1'b0;
        end
      end else if (baud_cnt == DCW'(DIV - 1)) begin
        baud_cnt <= '0;
        if (bit_idx == 4'd9) begin
          if (byte_idx == BW'(NB - 1)) begin
            up_active <= 1'b0;
            up_tgl    <= ~up_tgl;
          end else begin
            byte_idx <= nb_idx;
            bit_idx  <= '0;
            shreg    <= {1'b1, nb_byte};
            tx_r     <= 1'b0;
          end
        end else begin
          tx_r    <= shreg[0];
          shreg   <= {1'b1, shreg[8:1]};
          bit_idx <= bit_idx + 1'b1;
        end
      end else begin
        baud_cnt <= baud_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/capture_uart_dump_chk.sv
module capture_uart_dump_chk #(
  parameter int DEPTH = 16
) (
  input logic fast_clk,
  input logic fast_rst_n,
  input logic slow_clk,
  input logic slow_rst_n,
  input logic capture_req,
  input logic busy,
  input logic done,
  input logic uart_tx,
  input logic capturing,
  input logic waiting,
  input logic up_active
);
  localparam int CW = $clog2(DEPTH + 1) + 1;
  logic [CW-1:0] cap_len;

  always_ff @(posedge fast_clk or negedge fast_rst_n)
    if (!fast_rst_n)    cap_len <= '0;
    else if (capturing) cap_len <= cap_len + 1'b1;
    else                cap_len <= '0;

  assert_busy_start_R2: assert property (@(posedge fast_clk) disable iff (!fast_rst_n)
    $rose(busy) |-> $past(capture_req));
  assert_capture_len_R8: assert property (@(posedge fast_clk) disable iff (!fast_rst_n)
    $fell(capturing) |-> (cap_len == CW'(DEPTH)));
  assert_req_ignored_R6: assert property (@(posedge fast_clk) disable iff (!fast_rst_n)
    (waiting && capture_req) |=> !capturing);
  assert_flags_exclusive_R7: assert property (@(posedge fast_clk) disable iff (!fast_rst_n)
    !(busy && done));
  assert_done_after_busy_R7: assert property (@(posedge fast_clk) disable iff (!fast_rst_n)
    $rose(done) |-> $past(busy));
  assert_line_idle_R5: assert property (@(posedge slow_clk) disable iff (!slow_rst_n)
    !up_active |-> uart_tx);
  assert_start_low_R5: assert property (@(posedge slow_clk) disable iff (!slow_rst_n)
    $rose(up_active) |-> !uart_tx);
  assert_end_on_stop_R5: assert property (@(posedge slow_clk) disable iff (!slow_rst_n)
    $fell(up_active) |-> $past(uart_tx));
endmodule

bind capture_uart_dump capture_uart_dump_chk #(.DEPTH(DEPTH)) u_chk (
  .fast_clk(fast_clk), .fast_rst_n(fast_rst_n),
  .slow_clk(slow_clk), .slow_rst_n(slow_rst_n),
  .capture_req(capture_req), .busy(busy), .done(done), .uart_tx(uart_tx),
  .capturing(capturing), .waiting(waiting), .up_active(up_active)
);

// File: tb/sim_capture_uart_dump.sv
`timescale 1ns/1ps
module sim_capture_uart_dump;
  localparam int    DEPTH   = 16;
  localparam int    SLOW_HZ = 921600;
  localparam int    BAUD    = 115200;
  localparam real   SLOW_NS = 37.0;
  localparam real   BIT_NS  = SLOW_NS * (SLOW_HZ / BAUD);

  logic        fast_clk = 0, slow_clk = 0;
  logic        fast_rst_n = 0, slow_rst_n = 0;
  logic [13:0] adc_sample = '0;
  logic        capture_req = 0;
  logic        uart_tx, busy, done;

  int errors = 0, checks = 0;
  int rx_n = 0;
  logic [7:0] rx_q [64];
  bit finished = 0;
  int fcyc = 0;

  always #2.5 fast_clk = ~fast_clk;
  always #(SLOW_NS/2) slow_clk = ~slow_clk;
  always @(posedge fast_clk) fcyc++;

  capture_uart_dump #(.DEPTH(DEPTH), .SLOW_HZ(SLOW_HZ), .BAUD(BAUD)) u0 (
    .fast_clk(fast_clk), .fast_rst_n(fast_rst_n), .adc_sample(adc_sample),
    .capture_req(capture_req), .slow_clk(slow_clk), .slow_rst_n(slow_rst_n),
    .uart_tx(uart_tx), .busy(busy), .done(done));

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  function automatic logic [13:0] pat(int p, int k);
    case (p)
      0: return 14'((k * 1031) & 16'h3FFF);
      1: return (k % 2 == 0) ? 14'h1FFF : 14'h2000;
      2: return (k % 2 == 0) ? 14'h3FFF : 14'h0000;
      3: return 14'((k * 40503 + 12345) & 32'h3FFF);
      default: return 14'(1 << (k % 14));
    endcase
  endfunction

  // serial receiver model (R5)
  initial begin
    forever begin
      logic [7:0] b;
      @(negedge uart_tx);
      #(BIT_NS/2);
      check(uart_tx === 1'b0, "R5 start bit", uart_tx, 0);
      for (int i = 0; i < 8; i++) begin
        #(BIT_NS);
        b[i] = uart_tx;
      end
      #(BIT_NS);
      check(uart_tx === 1'b1, "R5 stop bit", uart_tx, 1);
      if (rx_n < 64) rx_q[rx_n] = b;
      rx_n++;
    end
  end

  initial begin
    #950000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", fcyc, 0);
    finish_run();
  end

  task automatic run_burst(int p, bit poke);
    int t;
    logic [15:0] w;
    rx_n = 0;
    @(negedge fast_clk); capture_req = 1;
    @(negedge fast_clk); capture_req = 0; adc_sample = pat(p, 0);
    check(busy === 1'b1 && done === 1'b0, "R2 busy after request", {busy, done}, 2);
    for (int k = 1; k < DEPTH; k++) begin
      @(negedge fast_clk); adc_sample = pat(p, k);
    end
    @(negedge fast_clk); adc_sample = 14'h1555;
    if (poke) begin
      repeat (400) @(negedge fast_clk);
      capture_req = 1;
      for (int j = 0; j < 20; j++) begin
        @(negedge fast_clk); capture_req = 0; adc_sample = 14'(j * 777);
      end
      check(busy === 1'b1, "R6 busy kept during upload", busy, 1);
    end
    t = 0;
    while (done !== 1'b1 && t < 60000) begin
      @(negedge fast_clk); t++;
    end
    check(done === 1'b1, "R7 done reached", done, 1);
    check(rx_n == 2*DEPTH, "R7 R8 all bytes before done", rx_n, 2*DEPTH);
    check(busy === 1'b0 && uart_tx === 1'b1, "R5 R7 idle at done", {busy, uart_tx}, 1);
    for (int k = 0; k < DEPTH && k*2+1 < 64; k++) begin
      w = {{2{pat(p, k)[13]}}, pat(p, k)};
      check(rx_q[2*k] === w[7:0], "R4 low byte first", rx_q[2*k], w[7:0]);
      check(rx_q[2*k+1] === w[15:8], "R3 R4 sign-extended high byte", rx_q[2*k+1], w[15:8]);
    end
    repeat (3000) @(negedge fast_clk);
    check(rx_n == 2*DEPTH, "R8 R6 no extra bytes", rx_n, 2*DEPTH);
    check(done === 1'b1 && busy === 1'b0, "R7 done held", {done, busy}, 2);
  endtask

  initial begin
    #20;
    check(uart_tx === 1'b1 && busy === 1'b0 && done === 1'b0, "R1 in reset", {uart_tx, busy, done}, 4);
    #80;
    @(negedge fast_clk); fast_rst_n = 1; slow_rst_n = 1;
    repeat (50) @(negedge fast_clk);
    check(uart_tx === 1'b1 && busy === 1'b0 && done === 1'b0, "R1 after reset", {uart_tx, busy, done}, 4);
    check(rx_n == 0, "R1 line quiet", rx_n, 0);
    for (int p = 0; p < 5; p++) run_burst(p, p == 2);
    finish_run();
  end
endmodule